// File: doc/BRIEF.md
# Flash Power-Mode and Command-Gating Controller

This block is the control core of a parallel NOR-style flash device. It samples the chip-select, write-strobe, output-strobe and power-down pins and the address bus on every clock. From them it tracks the operating mode: read, standby, automatic address-idle power saving, command setup, busy and deep power-down. It drives the output-buffer enable, a low-power flag, a busy flag, a sticky data-invalid flag and an 8-bit status byte.

Program and erase are two-cycle command sequences. A simple cycle timer stands in for the array operation. Chip select going high does not disturb a running operation. The power-down pin aborts the operation, clears the status and keeps the part deaf until separate read and write recovery delays have passed. All pins are active low and are assumed synchronous to `clk`. `rstN` is the power-on reset of the logic.

Top module: `flash_power_gate`

## Requirements
- R1: In a read-group mode (read, standby or power saving), chip select high moves the mode to standby (code 1) at the next edge. In standby, outEnable is 0 whatever the output strobe does, and lowPower is 1.
- R2: outEnable is 1 exactly when rpN is high, ceN and oeN are both low, read recovery has elapsed and the mode is not power-down (code 5). It holds in read, power saving, setup and busy.
- R3: In read mode with chip select low, an address held unchanged for QUIET_CYCLES consecutive edges moves the mode to power saving (code 2) with lowPower 1 and outputs still enabled. A changed address returns the mode to read (code 0) at the next edge.
- R4: A command is taken only on the first cycle in which weN and ceN are both low. With either one high, no command is taken.
- R5: Byte 0x40 enters setup (code 3) for program, and any next byte starts a busy period of PROG_CYCLES cycles. Byte 0x20 enters setup for erase, and byte 0xD0 next starts ERASE_CYCLES cycles. While busy (code 4), busy is 1 and status bit 7 is 0. Afterwards the mode is read and status bit 7 is 1.
- R6: In erase setup, a second byte other than 0xD0 sets status bit 5 (sequence error), starts no busy period and returns the mode to read.
- R7: Chip select high during busy leaves the mode at busy with lowPower 0 until the period ends.
- R8: rpN low puts the mode at power-down on the next edge with lowPower 1. outEnable drops at once, and every other input is ignored while rpN stays low.
- R9: rpN low during busy ends the operation at the next edge and sets dataBad. dataBad stays set until a later operation completes.
- R10: Entering power-down clears status bit 5. Status bits other than 7 and 5 are always 0.
- R11: After rpN returns high, outEnable stays 0 until READ_RECOVER edges with rpN high have passed.
- R12: After rpN returns high, commands are ignored until WRITE_RECOVER edges with rpN high have passed.
- R13: A first-cycle byte that is neither 0x40 nor 0x20 is ignored, and the mode stays in the read group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset of the logic, active low |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output strobe, active low |
| rpN | input | 1 | Power-down and abort pin, active low |
| addr | input | ADDR_W | Address bus, watched for idle |
| cmdData | input | 8 | Command or data byte |
| outEnable | output | 1 | Output-buffer enable |
| lowPower | output | 1 | Standby, power-saving or power-down indication |
| busy | output | 1 | Program or erase running |
| dataBad | output | 1 | Last operation was aborted |
| status | output | 8 | Bit 7 ready, bit 5 sequence error |
| mode | output | 3 | 0 read, 1 standby, 2 power saving, 3 setup, 4 busy, 5 power-down |

## Verification
Mode, busy, status and dataBad are registered, so each one is due on the first rising edge after the stimulus is applied. outEnable is combinational from the pins and the registered state, so it reflects the same cycle's pins against the state that edge produced. Counted windows are checked at their exact edge count: the power-saving entry, both recovery delays, and the busy length, which is checked on its last busy sample and its first ready sample. The bench drives pins on falling edges and samples 2 ns after the rising edge that consumes them, so every expected value belongs to one known edge.

// File: rtl/flash_pm_pkg.sv
`timescale 1ns/1ps
package flash_pm_pkg;

  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] CMD_PROG_SETUP    = 8'h40;
  localparam logic [CMD_W-1:0] CMD_ERASE_SETUP   = 8'h20;
  localparam logic [CMD_W-1:0] CMD_ERASE_CONFIRM = 8'hD0;

  typedef enum logic [2:0] {
    MODE_READ    = 3'd0,
    MODE_STANDBY = 3'd1,
    MODE_SAVE    = 3'd2,
    MODE_SETUP   = 3'd3,
    MODE_BUSY    = 3'd4,
    MODE_DOWN    = 3'd5
  } pmMode_t;

  typedef struct packed {
    logic startProg;
    logic startErase;
    logic clearStatus;
    logic setSeqErr;
    logic setAbort;
    logic opDone;
  } pmStrobe_t;

endpackage

// File: rtl/flash_pm_datapath.sv
`timescale 1ns/1ps
module flash_pm_datapath
  import flash_pm_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int QUIET_CYCLES  = 16,
  parameter int READ_RECOVER  = 20,
  parameter int WRITE_RECOVER = 30,
  parameter int PROG_CYCLES   = 200,
  parameter int ERASE_CYCLES  = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rpN,
  input  logic              ceN,
  input  logic [ADDR_W-1:0] addr,
  input  pmStrobe_t         strobe,
  input  logic              busyNow,
  output logic              rdReady,
  output logic              wrReady,
  output logic              addrQuiet,
  output logic              addrMoved,
  output logic              busyLast,
  output logic              seqErr,
  output logic              dataBad
);

  localparam int REC_MAX  = (READ_RECOVER > WRITE_RECOVER) ? READ_RECOVER : WRITE_RECOVER;
  localparam int REC_W    = $clog2(REC_MAX + 1);
  localparam int QUIET_W  = $clog2(QUIET_CYCLES + 1);
  localparam int TIME_MAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int TIME_W   = $clog2(TIME_MAX + 1);

  logic [REC_W-1:0]   recCount;
  logic [QUIET_W-1:0] quietCount;
  logic [ADDR_W-1:0]  addrPrev;
  logic [TIME_W-1:0]  opTimer;

  // recovery: counts edges with rpN high, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                         recCount <= REC_W'(REC_MAX);
    else if (!rpN)                     recCount <= '0;
    else if (recCount != REC_W'(REC_MAX)) recCount <= recCount + 1'b1;
  end

  assign rdReady = (recCount >= REC_W'(READ_RECOVER));
  assign wrReady = (recCount >= REC_W'(WRITE_RECOVER));

  // address idle detection
  assign addrMoved = (addr != addrPrev);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrPrev   <= '0;
      quietCount <= '0;
    end else begin
      addrPrev <= addr;
      if (addrMoved || ceN || !rpN)                 quietCount <= '0;
      else if (quietCount != QUIET_W'(QUIET_CYCLES)) quietCount <= quietCount + 1'b1;
    end
  end

  assign addrQuiet = (quietCount >= QUIET_W'(QUIET_CYCLES));

  // busy period timer
  always_ff @(posedge clk) begin
    if (!rstN)                      opTimer <= '0;
    else if (!rpN)                  opTimer <= '0;
    else if (strobe.startProg)      opTimer <= TIME_W'(PROG_CYCLES);
    else if (strobe.startErase)     opTimer <= TIME_W'(ERASE_CYCLES);
    else if (busyNow && opTimer > TIME_W'(1)) opTimer <= opTimer - 1'b1;
  end

  assign busyLast = (opTimer == TIME_W'(1));

  // status and abort flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqErr  <= 1'b0;
      dataBad <= 1'b0;
    end else begin
      if (strobe.clearStatus)    seqErr <= 1'b0;
      else if (strobe.setSeqErr) seqErr <= 1'b1;
      if (strobe.setAbort)       dataBad <= 1'b1;
      else if (strobe.opDone)    dataBad <= 1'b0;
    end
  end

  assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rpN |=> !seqErr);

  assert_abort_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busyNow && !rpN) |=> dataBad);

  assert_write_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !rpN |=> !wrReady);

endmodule

// File: rtl/flash_pm_ctrl.sv
`timescale 1ns/1ps
module flash_pm_ctrl
  import flash_pm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             weN,
  input  logic             rpN,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             wrReady,
  input  logic             addrQuiet,
  input  logic             addrMoved,
  input  logic             busyLast,
  output pmMode_t          mode,
  output pmStrobe_t        strobe
);

  pmMode_t modeNext;
  logic    eraseArmed, eraseArmedNext;
  logic    wrSelPrev;
  logic    wrSel, wrStrobe;

  assign wrSel    = !weN && !ceN;
  assign wrStrobe = wrSel && !wrSelPrev && rpN && wrReady;

  always_comb begin
    strobe         = '0;
    modeNext       = mode;
    eraseArmedNext = eraseArmed;
    if (!rpN) begin
      modeNext           = MODE_DOWN;
      strobe.clearStatus = 1'b1;
      if (mode == MODE_BUSY) strobe.setAbort = 1'b1;
    end else begin
      case (mode)
        MODE_BUSY: begin
          if (busyLast) begin
            modeNext      = MODE_READ;
            strobe.opDone = 1'b1;
          end
        end
        MODE_SETUP: begin
          if (wrStrobe) begin
            if (!eraseArmed) begin
              modeNext         = MODE_BUSY;
              strobe.startProg = 1'b1;
            end else if (cmdData == CMD_ERASE_CONFIRM) begin
              modeNext          = MODE_BUSY;
              strobe.startErase = 1'b1;
            end else begin
              modeNext         = MODE_READ;
              strobe.setSeqErr = 1'b1;
            end
          end
        end
        default: begin
          if (wrStrobe && cmdData == CMD_PROG_SETUP) begin
            modeNext       = MODE_SETUP;
            eraseArmedNext = 1'b0;
          end else if (wrStrobe && cmdData == CMD_ERASE_SETUP) begin
            modeNext       = MODE_SETUP;
            eraseArmedNext = 1'b1;
          end else if (ceN) begin
            modeNext = MODE_STANDBY;
          end else if (!addrMoved && addrQuiet) begin
            modeNext = MODE_SAVE;
          end else begin
            modeNext = MODE_READ;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode       <= MODE_READ;
      eraseArmed <= 1'b0;
      wrSelPrev  <= 1'b0;
    end else begin
      mode       <= modeNext;
      eraseArmed <= eraseArmedNext;
      wrSelPrev  <= wrSel;
    end
  end

  assert_down_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rpN |=> (mode == MODE_DOWN));

  assert_busy_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BUSY && rpN && !busyLast) |=> (mode == MODE_BUSY));

endmodule

// File: rtl/flash_power_gate.sv
`timescale 1ns/1ps
module flash_power_gate
  import flash_pm_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int QUIET_CYCLES  = 16,
  parameter int READ_RECOVER  = 20,
  parameter int WRITE_RECOVER = 30,
  parameter int PROG_CYCLES   = 200,
  parameter int ERASE_CYCLES  = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              rpN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmdData,
  output logic              outEnable,
  output logic              lowPower,
  output logic              busy,
  output logic              dataBad,
  output logic [7:0]        status,
  output logic [2:0]        mode
);

  pmMode_t   modeState;
  pmStrobe_t strobe;
  logic rdReady, wrReady, addrQuiet, addrMoved, busyLast, seqErr;

  flash_pm_ctrl ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .rpN(rpN),
    .cmdData(cmdData), .wrReady(wrReady), .addrQuiet(addrQuiet),
    .addrMoved(addrMoved), .busyLast(busyLast),
    .mode(modeState), .strobe(strobe)
  );

  flash_pm_datapath #(
    .ADDR_W(ADDR_W), .QUIET_CYCLES(QUIET_CYCLES), .READ_RECOVER(READ_RECOVER),
    .WRITE_RECOVER(WRITE_RECOVER), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) dpath (
    .clk(clk), .rstN(rstN), .rpN(rpN), .ceN(ceN), .addr(addr),
    .strobe(strobe), .busyNow(busy),
    .rdReady(rdReady), .wrReady(wrReady), .addrQuiet(addrQuiet),
    .addrMoved(addrMoved), .busyLast(busyLast), .seqErr(seqErr), .dataBad(dataBad)
  );

  assign busy      = (modeState == MODE_BUSY);
  assign mode      = modeState;
  assign lowPower  = (modeState == MODE_STANDBY) || (modeState == MODE_SAVE) ||
                     (modeState == MODE_DOWN);
  assign outEnable = rpN && !ceN && !oeN && rdReady && (modeState != MODE_DOWN);
  assign status    = {!busy, 1'b0, seqErr, 5'b0};

  assert_standby_dark_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || !rpN) |-> !outEnable);

endmodule

// File: tb/flash_power_gate_test.sv
`timescale 1ns/1ps
module flash_power_gate_test;

  logic clk = 1'b0;
  logic rstN, ceN, weN, oeN, rpN;
  logic [7:0] addr, cmdData;
  logic outEnable, lowPower, busy, dataBad;
  logic [7:0] status;
  logic [2:0] mode;

  int checks = 0;
  int fails  = 0;
  logic [7:0] dAddr = 8'h40;

  always #4 clk = ~clk;

  flash_power_gate #(
    .ADDR_W(8), .QUIET_CYCLES(3), .READ_RECOVER(2), .WRITE_RECOVER(4),
    .PROG_CYCLES(5), .ERASE_CYCLES(8)
  ) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .rpN(rpN),
    .addr(addr), .cmdData(cmdData), .outEnable(outEnable), .lowPower(lowPower),
    .busy(busy), .dataBad(dataBad), .status(status), .mode(mode)
  );

  // row: {ceN,weN,oeN,rpN}, addr, data, mode, outEnable, lowPower, status
  localparam logic [32:0] VEC [16] = '{
    {4'b1101, 8'h00, 8'h00, 3'd1, 1'b0, 1'b1, 8'h80}, // R1 oe low, still dark
    {4'b0101, 8'h10, 8'h00, 3'd0, 1'b1, 1'b0, 8'h80}, // R2
    {4'b0101, 8'h10, 8'h00, 3'd0, 1'b1, 1'b0, 8'h80},
    {4'b0101, 8'h10, 8'h00, 3'd0, 1'b1, 1'b0, 8'h80},
    {4'b0101, 8'h10, 8'h00, 3'd0, 1'b1, 1'b0, 8'h80},
    {4'b0101, 8'h10, 8'h00, 3'd2, 1'b1, 1'b1, 8'h80}, // R3 idle entry
    {4'b0101, 8'h11, 8'h00, 3'd0, 1'b1, 1'b0, 8'h80}, // R3 exit
    {4'b0111, 8'h11, 8'h00, 3'd0, 1'b0, 1'b0, 8'h80}, // R2 oe high
    {4'b0011, 8'h11, 8'hFF, 3'd0, 1'b0, 1'b0, 8'h80}, // R13 unknown byte
    {4'b0111, 8'h11, 8'h00, 3'd0, 1'b0, 1'b0, 8'h80},
    {4'b1011, 8'h11, 8'h40, 3'd1, 1'b0, 1'b1, 8'h80}, // R4 ce high blocks
    {4'b0111, 8'h11, 8'h00, 3'd0, 1'b0, 1'b0, 8'h80},
    {4'b0011, 8'h11, 8'h20, 3'd3, 1'b0, 1'b0, 8'h80}, // R5 erase setup
    {4'b0111, 8'h11, 8'h00, 3'd3, 1'b0, 1'b0, 8'h80},
    {4'b0011, 8'h11, 8'h33, 3'd0, 1'b0, 1'b0, 8'hA0}, // R6 bad confirm
    {4'b0111, 8'h12, 8'h00, 3'd0, 1'b0, 1'b0, 8'hA0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic o, input logic r,
                      input logic [7:0] d);
    @(negedge clk);
    ceN = c; weN = w; oeN = o; rpN = r; cmdData = d; addr = dAddr;
    dAddr = dAddr + 8'd1;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1; rpN = 1'b1;
    addr = 8'h00; cmdData = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    chk("reset", "mode", 32'(mode), 32'd0);
    chk("reset", "status", 32'(status), 32'h80);
    chk("reset", "busy", 32'(busy), 32'd0);
    chk("reset", "dataBad", 32'(dataBad), 32'd0);
    chk("reset", "outEnable", 32'(outEnable), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      {ceN, weN, oeN, rpN} = VEC[i][32:29];
      addr    = VEC[i][28:21];
      cmdData = VEC[i][20:13];
      @(posedge clk);
      #2;
      chk($sformatf("R1-table row %0d", i), "mode", 32'(mode), 32'(VEC[i][12:10]));
      chk($sformatf("R2 table row %0d", i), "outEnable", 32'(outEnable), 32'(VEC[i][9]));
      chk($sformatf("R3 table row %0d", i), "lowPower", 32'(lowPower), 32'(VEC[i][8]));
      chk($sformatf("R5 table row %0d", i), "status", 32'(status), 32'(VEC[i][7:0]));
    end

    // program sequence with chip select high during busy (R5, R7)
    step(0, 0, 1, 1, 8'h40);
    chk("R5", "mode setup", 32'(mode), 32'd3);
    step(0, 1, 1, 1, 8'h00);
    chk("R5", "mode setup hold", 32'(mode), 32'd3);
    step(0, 0, 0, 1, 8'hAB);
    chk("R5", "mode busy", 32'(mode), 32'd4);
    chk("R5", "busy", 32'(busy), 32'd1);
    chk("R5", "status busy", 32'(status), 32'h20);
    chk("R2", "outEnable in busy", 32'(outEnable), 32'd1);
    for (int k = 0; k < 4; k++) begin
      step(1, 1, 1, 1, 8'h00);
      chk("R7", "mode ce high", 32'(mode), 32'd4);
      chk("R7", "lowPower ce high", 32'(lowPower), 32'd0);
    end
    step(1, 1, 1, 1, 8'h00);
    chk("R5", "mode done", 32'(mode), 32'd0);
    chk("R5", "status ready", 32'(status), 32'hA0);
    step(1, 1, 1, 1, 8'h00);
    chk("R1", "standby", 32'(mode), 32'd1);

    // erase then abort by power-down (R8, R9, R10)
    step(0, 0, 1, 1, 8'h20);
    chk("R5", "erase setup", 32'(mode), 32'd3);
    step(0, 1, 1, 1, 8'h00);
    step(0, 0, 1, 1, 8'hD0);
    chk("R5", "erase busy", 32'(mode), 32'd4);
    step(0, 1, 1, 1, 8'h00);
    chk("R5", "erase still busy", 32'(busy), 32'd1);
    step(0, 0, 0, 0, 8'h40);
    chk("R8", "mode down", 32'(mode), 32'd5);
    chk("R8", "outEnable down", 32'(outEnable), 32'd0);
    chk("R8", "lowPower down", 32'(lowPower), 32'd1);
    chk("R9", "busy aborted", 32'(busy), 32'd0);
    chk("R9", "dataBad set", 32'(dataBad), 32'd1);
    chk("R10", "status cleared", 32'(status), 32'h80);
    step(0, 0, 0, 0, 8'h40);
    chk("R8", "inputs ignored", 32'(mode), 32'd5);

    // recovery (R11, R12)
    step(0, 1, 0, 1, 8'h00);
    chk("R11", "mode after release", 32'(mode), 32'd0);
    chk("R11", "outEnable early", 32'(outEnable), 32'd0);
    step(0, 1, 0, 1, 8'h00);
    chk("R11", "outEnable recovered", 32'(outEnable), 32'd1);
    step(0, 0, 1, 1, 8'h40);
    chk("R12", "early command ignored", 32'(mode), 32'd0);
    step(0, 1, 1, 1, 8'h00);
    step(0, 0, 1, 1, 8'h40);
    chk("R12", "command accepted", 32'(mode), 32'd3);
    step(0, 1, 1, 1, 8'h00);
    step(0, 0, 1, 1, 8'h5A);
    chk("R9", "dataBad kept while busy", 32'(dataBad), 32'd1);
    for (int k = 0; k < 4; k++) step(0, 1, 1, 1, 8'h00);
    chk("R5", "last busy sample", 32'(mode), 32'd4);
    step(0, 1, 1, 1, 8'h00);
    chk("R5", "program done", 32'(mode), 32'd0);
    chk("R9", "dataBad cleared", 32'(dataBad), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule